// File: doc/BRIEF.md
# Processor swap port with interrupt steering

This block is a small write-only control register for a system that carries two processors, here called CPU A and CPU B, of which only one runs at a time. Software writes a three-bit word to the port to choose the active processor, to arm a mask that also acts as an automatic swap trigger, and to raise a swap-interrupt request that the newly started processor can find.

Alongside the register, the block steers the incoming standard request (`irqIn`) and non-maskable request (`nmiIn`) to the interrupt inputs of the processor that is running. The other processor's inputs are held low. When CPU A runs with the mask armed, both processors' inputs are blocked. Any request that arrives then switches the select over to CPU B on the next clock edge, so that CPU B takes over and serves it. The clock handover between the processors and the programming of any interrupt controller lie outside this block.

Top module: `swap_port`

## Requirements
- R1: After reset is released, selB is 0 (CPU A active), the mask is off and swapInt is 0. In this state irqIn reaches irqA and nmiIn reaches nmiA.
- R2: A write is the cycle in which cs and wr are both 1. On the next rising edge it loads all three fields together: dataIn[0] is the mask (1 = armed), dataIn[1] is swapInt, and dataIn[2] is the select (1 = CPU B). When cs or wr is 0, the register keeps its value.
- R3: With selB = 0 and the mask off, irqA equals irqIn and nmiA equals nmiIn in the same cycle, and irqB and nmiB are 0.
- R4: With selB = 0 and the mask armed, irqA, nmiA, irqB and nmiB are all 0, whatever irqIn and nmiIn are.
- R5: With selB = 0 and the mask armed, a 1 on irqIn or on nmiIn in a cycle with no write sets selB to 1 at the next rising edge. The mask and swapInt keep their values.
- R6: With selB = 1, irqB equals irqIn and nmiB equals nmiIn in the same cycle, and irqA and nmiA are 0. This holds whether the mask is armed or not.
- R7: swapInt stays at 1 until a write with dataIn[1] = 0 or a reset clears it. An automatic swap does not change swapInt.
- R8: When a write and an automatic-swap condition occur in the same cycle, the written value is what the register holds after the edge.
- R9: No interrupt output is ever 1 for the processor that selB does not name.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Port select |
| wr | input | 1 | Write strobe |
| dataIn | input | 3 | Write data: bit 0 mask, bit 1 swap interrupt, bit 2 select |
| irqIn | input | 1 | Incoming standard interrupt request |
| nmiIn | input | 1 | Incoming non-maskable interrupt request |
| selB | output | 1 | 1 when CPU B is active, 0 when CPU A is active |
| swapInt | output | 1 | Latched swap-interrupt request |
| irqA | output | 1 | Standard request to CPU A |
| nmiA | output | 1 | Non-maskable request to CPU A |
| irqB | output | 1 | Standard request to CPU B |
| nmiB | output | 1 | Non-maskable request to CPU B |

## Verification
The bench aims at the mask's two roles. It sends a lone NMI and then a lone standard request while CPU A runs with the mask armed. A design that swaps only on one request type would stay on CPU A and leave the request unserved, and a design that leaks a request through the mask would drive CPU A after the mask was armed. With CPU B active, it toggles the mask and applies requests. A design that let the mask gate CPU B would drop requests, and one that swapped back would hand them to the idle processor. It also collides a write of "CPU A, mask armed" with a pending request and checks that the write wins. It writes with only one strobe and checks that nothing changes, and it checks that swapInt survives an automatic swap. A design that got either wrong would corrupt the register.

// File: rtl/swap_pkg.sv
package swap_pkg;
  localparam int MASK_BIT = 0;
  localparam int SWAP_BIT = 1;
  localparam int SEL_BIT  = 2;
  localparam int REG_W    = SEL_BIT + 1;

  typedef struct packed {
    logic loadReg;
    logic autoSwap;
  } swapStrobe_t;
endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cs,
  input  logic        wr,
  input  logic        selB,
  input  logic        maskOn,
  input  logic        irqIn,
  input  logic        nmiIn,
  output swapStrobe_t strobe,
  output logic        irqA,
  output logic        nmiA,
  output logic        irqB,
  output logic        nmiB
);
  logic routeA;
  logic anyReq;

  always_comb begin
    anyReq          = irqIn | nmiIn;
    routeA          = ~selB & ~maskOn;
    strobe.loadReg  = cs & wr;
    strobe.autoSwap = ~selB & maskOn & anyReq;
    irqA            = routeA & irqIn;
    nmiA            = routeA & nmiIn;
    irqB            = selB & irqIn;
    nmiB            = selB & nmiIn;
  end

  // R9: the idle processor never sees a request
  p_idle_cpu_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (selB |-> !(irqA || nmiA)) and (!selB |-> !(irqB || nmiB)));

  // R4: an armed mask on CPU A blocks everything
  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!selB && maskOn) |-> !(irqA || nmiA || irqB || nmiB));

  // R6: CPU B gets every request whatever the mask
  p_cpu_b_routes_r6: assert property (@(posedge clk) disable iff (!rstN)
    selB |-> (irqB == irqIn && nmiB == nmiIn));
endmodule

// File: rtl/swap_dp.sv
module swap_dp
  import swap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  swapStrobe_t      strobe,
  input  logic [REG_W-1:0] dataIn,
  output logic             selB,
  output logic             maskOn,
  output logic             swapInt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selB    <= 1'b0;
      maskOn  <= 1'b0;
      swapInt <= 1'b0;
    end else if (strobe.loadReg) begin
      selB    <= dataIn[SEL_BIT];
      maskOn  <= dataIn[MASK_BIT];
      swapInt <= dataIn[SWAP_BIT];
    end else if (strobe.autoSwap) begin
      selB    <= 1'b1;
    end
  end

  // R2 / R8: a write loads all three fields, auto-swap or not
  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadReg |=> (selB == $past(dataIn[SEL_BIT]) &&
                        maskOn == $past(dataIn[MASK_BIT]) &&
                        swapInt == $past(dataIn[SWAP_BIT])));

  // R5: the auto-swap lands on CPU B next edge
  p_auto_swap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.autoSwap && !strobe.loadReg) |=> selB);

  // R7: swapInt and the mask hold without a write
  p_swapint_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadReg |=> ($stable(swapInt) && $stable(maskOn)));
endmodule

// File: rtl/swap_port.sv
module swap_port
  import swap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cs,
  input  logic             wr,
  input  logic [REG_W-1:0] dataIn,
  input  logic             irqIn,
  input  logic             nmiIn,
  output logic             selB,
  output logic             swapInt,
  output logic             irqA,
  output logic             nmiA,
  output logic             irqB,
  output logic             nmiB
);
  swapStrobe_t strobe;
  logic        maskOn;

  swap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .wr(wr), .selB(selB), .maskOn(maskOn),
    .irqIn(irqIn), .nmiIn(nmiIn), .strobe(strobe),
    .irqA(irqA), .nmiA(nmiA), .irqB(irqB), .nmiB(nmiB)
  );

  swap_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .selB(selB), .maskOn(maskOn), .swapInt(swapInt)
  );
endmodule

// File: tb/sim_swap_port.sv
`timescale 1ns/100ps
module sim_swap_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, wr = 1'b0;
  logic [2:0] dataIn = 3'b000;
  logic       irqIn = 1'b0, nmiIn = 1'b0;
  logic       selB, swapInt, irqA, nmiA, irqB, nmiB;

  swap_port u0 (
    .clk(clk), .rstN(rstN), .cs(cs), .wr(wr), .dataIn(dataIn),
    .irqIn(irqIn), .nmiIn(nmiIn), .selB(selB), .swapInt(swapInt),
    .irqA(irqA), .nmiA(nmiA), .irqB(irqB), .nmiB(nmiB)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [5:0] vec;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];
  event     sampleEv;
  int       nRun = 0, nFail = 0;
  logic     mSel = 1'b0, mMask = 1'b0, mSw = 1'b0;

  // monitor: pop and compare {selB,swapInt,irqA,nmiA,irqB,nmiB}
  always @(sampleEv) begin
    while (scoreQ.size() > 0) begin
      expItem_t it;
      logic [5:0] act;
      it  = scoreQ.pop_front();
      act = {selB, swapInt, irqA, nmiA, irqB, nmiB};
      nRun++;
      if (act !== it.vec) begin
        nFail++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.vec);
      end
      if ((selB && (irqA || nmiA)) || (!selB && (irqB || nmiB))) begin
        nRun++;
        nFail++;
        $display("FAIL R9 (%s): idle CPU driven, actual %b expected none", it.tag, act);
      end
    end
  end

  // driver: apply inputs, predict outputs, then advance the model one edge
  task automatic step(input logic c, input logic w, input logic [2:0] d,
                      input logic irq, input logic nmi, input string tag);
    expItem_t it;
    logic ra;
    @(negedge clk);
    cs = c; wr = w; dataIn = d; irqIn = irq; nmiIn = nmi;
    #1;
    ra = !mSel && !mMask;
    it.vec = {mSel, mSw, ra & irq, ra & nmi, mSel & irq, mSel & nmi};
    it.tag = tag;
    scoreQ.push_back(it);
    ->sampleEv;
    if (c && w) begin
      mSel = d[2]; mSw = d[1]; mMask = d[0];
    end else if (!mSel && mMask && (irq || nmi)) begin
      mSel = 1'b1;
    end
  endtask

  initial begin
    #100000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    step(0,0,3'b000,0,0,"R1 reset state");
    step(0,0,3'b000,1,0,"R1 R3 irq to A");
    step(0,0,3'b000,0,1,"R3 nmi to A");
    step(0,0,3'b000,1,1,"R3 both to A");
    step(1,0,3'b111,0,0,"R2 cs only ignored");
    step(0,1,3'b111,0,0,"R2 wr only ignored");
    step(0,0,3'b000,1,1,"R2 state unchanged");
    step(1,1,3'b011,0,0,"R2 write mask+swapint");
    step(0,0,3'b000,1,1,"R4 mask blocks, auto swap R5");
    step(0,0,3'b000,0,0,"R5 swapped to B, R7 swapint kept");
    step(0,0,3'b000,1,0,"R6 irq to B mask on");
    step(1,1,3'b110,0,1,"R6 nmi to B, write mask off");
    step(0,0,3'b000,1,1,"R6 both to B mask off R7");
    step(1,1,3'b001,0,0,"R2 back to A mask armed");
    step(0,0,3'b000,0,1,"R5 lone nmi triggers swap");
    step(0,0,3'b000,0,0,"R5 on B after nmi");
    step(1,1,3'b001,0,0,"R2 back to A armed");
    step(0,0,3'b000,1,0,"R5 lone irq triggers swap");
    step(0,0,3'b000,1,0,"R5 on B after irq");
    step(1,1,3'b001,0,0,"R2 back to A armed");
    step(1,1,3'b001,1,1,"R8 write collides with request");
    step(0,0,3'b000,0,0,"R8 write won, still A");
    step(1,1,3'b000,0,0,"R7 clear swapint");
    step(0,0,3'b000,1,1,"R7 swapint cleared, R3 to A");
    step(1,1,3'b110,0,0,"R2 write B with swapint");
    step(0,0,3'b000,0,0,"R7 swapint held");
    step(0,0,3'b000,1,1,"R6 to B mask off");
    @(negedge clk);
    #1;
    ->sampleEv;
    #1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule